// File: doc/BRIEF.md
# Programmable Interrupt Timer

This block is a countdown timer for a per-processor interrupt controller. Software programs a timer entry through a small register port. The entry holds an interrupt vector, a mask flag and a periodic/one-shot selector. Software also sets a clock divide code and writes an initial count. The counter moves down by one on every prescaled tick, where the tick spacing is a power of two of the input clock. Software can read the current count at any time.

Writing the initial count restarts timing from that moment. In periodic mode the count runs from the initial value down to zero and reloads, so one period spans the initial count plus one ticks. In one-shot mode the count stops at zero and produces a single expiry on the tick after it reaches zero. Each expiry that is not masked raises a one-clock interrupt request carrying the programmed vector.

Top module: `lvt_timer`

## Requirements
- R1: After reset the timer entry reads 0x0001_0000 (masked, one-shot, vector 0). The divide register, initial count and current count read 0, and no interrupt request is raised.
- R2: Register map on `regAddr`: 0 is the timer entry (bits 7:0 vector, bit 16 mask, bit 17 mode with 1 = periodic), 1 is the initial count, 2 is the current count, and 3 is the divide register (bits 0, 1 and 3). Bits that are not stored read as zero.
- R3: The divide code is {bit3, bit1, bit0}. Codes 0 to 6 give a tick every 2, 4, 8, 16, 32, 64 or 128 clocks, and code 7 gives a tick every clock.
- R4: A write of value N to the initial count makes the current count read N after that clock edge and restarts the prescaler phase. With divide D, the k-th tick lands on the k·D-th clock edge after the write edge.
- R5: In periodic mode with N > 0, after k ticks the current count reads N − (k mod (N+1)). An interrupt request is raised on every tick where k is a nonzero multiple of N+1.
- R6: In periodic mode with an initial count of 0, the count stays 0 and no interrupt request is ever raised.
- R7: In one-shot mode, after k ticks the count reads N − k and holds at 0 once k ≥ N. Exactly one interrupt request occurs, at tick N+1, and none occurs when N is 0.
- R8: When the mask bit is set, no interrupt request is raised, and the count keeps following R5/R7.
- R9: `irqValid` is high for exactly one clock after the edge that processes an expiring tick, with `irqVector` equal to the entry's vector.
- R10: A divide register write does not restart the current tick interval. The interval in progress finishes with the old divisor, and the new divisor applies from the following interval.
- R11: Writes to address 2 (current count) have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `regAddr` |
| irqValid | output | 1 | One-clock interrupt request pulse |
| irqVector | output | 8 | Vector carried with the request |

## Verification
The bench goes after the off-by-one in the period. A design that expires when the count reaches zero fires one tick early in both modes, and one that reloads to N−1 shortens every period. It covers a periodic zero count, which a careless design turns into a request on every tick, and a one-shot run held long past expiry, which catches repeated requests. A divide change in mid-interval exposes designs that apply the new divisor at once or restart the phase. Masked runs and writes to the current count check that the count carries on and that no request leaks out.

// File: rtl/lvt_timer_pkg.sv
package lvt_timer_pkg;

  typedef struct packed {
    logic load;
    logic tick;
    logic periodic;
    logic masked;
  } tmrStrobe_t;

  localparam logic [1:0] ADDR_ENTRY = 2'd0;
  localparam logic [1:0] ADDR_INIT  = 2'd1;
  localparam logic [1:0] ADDR_CUR   = 2'd2;
  localparam logic [1:0] ADDR_DIV   = 2'd3;

  localparam int unsigned SHIFT_W = 3;

  function automatic logic [SHIFT_W-1:0] codeToShift(input logic [2:0] code);
    return (code == 3'b111) ? '0 : SHIFT_W'(code + 3'd1);
  endfunction

endpackage

// File: rtl/lvt_timer_ctrl.sv
module lvt_timer_ctrl
  import lvt_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  output tmrStrobe_t        strobe,
  output logic [DATA_W-1:0] initCount,
  output logic [VEC_W-1:0]  entryVec,
  output logic [2:0]        divCode
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic               entryMask, entryPeriodic;
  logic [PRE_W-1:0]   preCnt;
  logic [SHIFT_W-1:0] activeShift;
  logic [PRE_W-1:0]   preLimit;
  logic               loadHit;

  assign loadHit  = wrEn && (regAddr == ADDR_INIT);
  assign preLimit = PRE_W'((32'd1 << activeShift) - 32'd1);

  always_comb begin
    strobe.load     = loadHit;
    strobe.tick     = (preCnt == preLimit);
    strobe.periodic = entryPeriodic;
    strobe.masked   = entryMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryMask     <= 1'b1;
      entryPeriodic <= 1'b0;
      entryVec      <= '0;
      divCode       <= '0;
      initCount     <= '0;
    end else if (wrEn) begin
      case (regAddr)
        ADDR_ENTRY: begin
          entryVec      <= wrData[VEC_W-1:0];
          entryMask     <= wrData[16];
          entryPeriodic <= wrData[17];
        end
        ADDR_INIT: initCount <= wrData;
        ADDR_DIV:  divCode   <= {wrData[3], wrData[1], wrData[0]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt      <= '0;
      activeShift <= '0;
    end else if (loadHit || strobe.tick) begin
      preCnt      <= '0;
      activeShift <= codeToShift(divCode);
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assert_load_restarts_prescaler_R4: assert property (@(posedge clk) disable iff (!rstN)
    loadHit |=> (preCnt == '0));

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |=> (!strobe.tick || activeShift == '0));

endmodule

// File: rtl/lvt_timer_dp.sv
module lvt_timer_dp
  import lvt_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [DATA_W-1:0] initCount,
  input  logic [VEC_W-1:0]  entryVec,
  output logic [DATA_W-1:0] curCount,
  output logic              irqValid,
  output logic [VEC_W-1:0]  irqVector
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCount  <= '0;
      armed     <= 1'b0;
      irqValid  <= 1'b0;
      irqVector <= '0;
    end else begin
      irqValid <= 1'b0;
      if (strobe.load) begin
        curCount <= loadVal;
        armed    <= (loadVal != '0);
      end else if (strobe.tick) begin
        if (curCount != '0) begin
          curCount <= curCount - 1'b1;
        end else if (strobe.periodic) begin
          curCount  <= initCount;
          irqValid  <= (initCount != '0) && !strobe.masked;
          irqVector <= entryVec;
        end else if (armed) begin
          armed     <= 1'b0;
          irqValid  <= !strobe.masked;
          irqVector <= entryVec;
        end
      end
    end
  end

  assert_irq_needs_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> $past(strobe.tick));

  assert_irq_single_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |=> !irqValid);

  assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && strobe.masked && !strobe.load) |=> !irqValid);

  assert_periodic_zero_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && strobe.periodic && initCount == '0 && !strobe.load) |=> !irqValid);

  assert_oneshot_holds_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.periodic && !strobe.load && curCount == '0) |=> (curCount == '0));

endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
  import lvt_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqValid,
  output logic [VEC_W-1:0]  irqVector
);
  tmrStrobe_t        strobe;
  logic [DATA_W-1:0] initCount, curCount;
  logic [VEC_W-1:0]  entryVec;
  logic [2:0]        divCode;

  lvt_timer_ctrl #(.DATA_W(DATA_W), .VEC_W(VEC_W)) ctrlInst (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .strobe(strobe), .initCount(initCount), .entryVec(entryVec), .divCode(divCode)
  );

  lvt_timer_dp #(.DATA_W(DATA_W), .VEC_W(VEC_W)) dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadVal(wrData),
    .initCount(initCount), .entryVec(entryVec), .curCount(curCount),
    .irqValid(irqValid), .irqVector(irqVector)
  );

  always_comb begin
    rdData = '0;
    case (regAddr)
      ADDR_ENTRY: begin
        rdData[VEC_W-1:0] = entryVec;
        rdData[16]        = strobe.masked;
        rdData[17]        = strobe.periodic;
      end
      ADDR_INIT: rdData = initCount;
      ADDR_CUR:  rdData = curCount;
      default: begin
        rdData[0] = divCode[0];
        rdData[1] = divCode[1];
        rdData[3] = divCode[2];
      end
    endcase
  end

endmodule

// File: tb/lvt_timer_test.sv
module lvt_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  regAddr = 2'd2;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqValid;
  logic [7:0]  irqVector;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  lvt_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .irqValid(irqValid), .irqVector(irqVector)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; regAddr = 2'd2;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a; #1; d = rdData; regAddr = 2'd2; #1;
  endtask

  function automatic logic [31:0] divWord(input logic [2:0] code);
    return {28'd0, code[2], 1'b0, code[1], code[0]};
  endfunction

  function automatic logic [31:0] expCount(input int n, input int ticks, input bit per);
    if (per) return 32'(n - (ticks % (n + 1)));
    return (ticks >= n) ? 32'd0 : 32'(n - ticks);
  endfunction

  function automatic bit expIrq(input int n, input int t, input int d,
                                input bit per, input bit msk);
    int k;
    if (msk || n == 0 || t == 0 || (t % d) != 0) return 1'b0;
    k = t / d;
    if (per) return (k % (n + 1)) == 0;
    return k == n + 1;
  endfunction

  initial begin
    #2_000_000;
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(2'd0, rv); check(rv == 32'h0001_0000, "R1 entry", rv, 32'h0001_0000);
    readReg(2'd1, rv); check(rv == 0, "R1 initial count", rv, 0);
    readReg(2'd2, rv); check(rv == 0, "R1 current count", rv, 0);
    readReg(2'd3, rv); check(rv == 0, "R1 divide", rv, 0);
    check(irqValid == 1'b0, "R1 irq idle", 32'(irqValid), 0);

    // R6 periodic with zero count, divide by one
    regWrite(2'd0, 32'h0002_0042);
    regWrite(2'd3, divWord(3'd7));
    regWrite(2'd1, 32'd0);
    for (int t = 1; t <= 40; t++) begin
      @(negedge clk);
      check(irqValid == 1'b0, "R6 no irq", 32'(irqValid), 0);
      readReg(2'd2, rv); check(rv == 0, "R6 count", rv, 0);
    end

    // R7 one-shot with zero count
    regWrite(2'd0, 32'h0000_0042);
    regWrite(2'd1, 32'd0);
    for (int t = 1; t <= 20; t++) begin
      @(negedge clk);
      check(irqValid == 1'b0, "R7 zero one-shot", 32'(irqValid), 0);
    end

    // R10 divide change mid-interval: divide by 4, then switch to divide by 2
    regWrite(2'd0, 32'h0002_0011);
    regWrite(2'd3, divWord(3'd1));
    regWrite(2'd1, 32'd100);
    wrEn = 1'b1; regAddr = 2'd3; wrData = divWord(3'd0);
    @(negedge clk);
    wrEn = 1'b0; regAddr = 2'd2;
    @(negedge clk); @(negedge clk);
    readReg(2'd2, rv); check(rv == 100, "R10 before old tick", rv, 100);
    @(negedge clk);
    readReg(2'd2, rv); check(rv == 99, "R10 old interval kept", rv, 99);
    @(negedge clk);
    readReg(2'd2, rv); check(rv == 99, "R10 new divisor mid", rv, 99);
    @(negedge clk);
    readReg(2'd2, rv); check(rv == 98, "R10 new divisor tick", rv, 98);

    // Random runs: R2 R3 R4 R5 R7 R8 R9 R11
    for (int it = 0; it < 40; it++) begin
      int n, sel, d, cycles, poke;
      bit per, msk;
      logic [2:0] code;
      logic [7:0] vec;
      logic [31:0] junk, entry;
      n   = $urandom_range(0, 12);
      sel = $urandom_range(0, 3);
      code = (sel == 0) ? 3'd7 : 3'(sel - 1);
      d   = 1 << sel;
      per = 1'($urandom_range(0, 1));
      msk = ($urandom_range(0, 3) == 0);
      vec = 8'($urandom);
      junk = $urandom;
      entry = (junk & ~32'h0003_00FF) | {14'd0, per, msk, 8'd0, vec};
      regWrite(2'd0, entry);
      readReg(2'd0, rv);
      check(rv == (entry & 32'h0003_00FF), "R2 entry readback", rv, entry & 32'h0003_00FF);
      regWrite(2'd3, (junk & 32'hFFFF_FFF4) | divWord(code));
      readReg(2'd3, rv);
      check(rv == divWord(code), "R2 divide readback", rv, divWord(code));
      regWrite(2'd1, 32'(n));
      readReg(2'd1, rv); check(rv == 32'(n), "R2 initial readback", rv, 32'(n));
      readReg(2'd2, rv); check(rv == 32'(n), "R4 load value", rv, 32'(n));
      cycles = (n + 1) * d * 3 + 4;
      poke = $urandom_range(1, cycles);
      for (int t = 1; t <= cycles; t++) begin
        bit ei;
        logic [31:0] ec;
        if (t == poke) begin
          wrEn = 1'b1; regAddr = 2'd2; wrData = $urandom;
        end
        @(negedge clk);
        wrEn = 1'b0; regAddr = 2'd2;
        #1;
        ei = expIrq(n, t, d, per, msk);
        ec = expCount(n, t / d, per);
        check(irqValid == ei, per ? "R5 R8 periodic irq" : "R7 R8 one-shot irq",
              32'(irqValid), 32'(ei));
        if (ei)
          check(irqVector == vec, "R9 vector", 32'(irqVector), 32'(vec));
        check(rdData == ec, (t >= poke) ? "R11 R3 count after poke" : "R3 R4 count",
              rdData, ec);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule